// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for a single read or write burst in a two-bank synchronous DRAM. A start strobe captures a starting column, a burst length code and an ordering choice. From the next cycle on, the block presents one column per clock together with a valid flag. It raises a done flag on the final beat of a finite burst.

Two orderings are supported. In the linear ordering, the low bits count up inside an aligned block. In the interleaved ordering, the low bits are XORed with the beat index. The linear ordering also offers a whole-row mode that wraps around the 512-column row and keeps running until something ends it. A running burst can be halted by a stop strobe on any cycle. It can also be replaced on any cycle by a fresh start strobe, so column commands one clock apart are honoured.

Top module: `burst_col_gen`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, `colValid`, `burstDone` and `modeErr` are 0.
- R2: A `startStb` sampled at a rising edge makes `colValid` 1 and `colOut` equal to the sampled `startCol` in the following cycle. Each later beat appears one cycle after the previous one.
- R3: With `interleave`=0 and a finite length BL, beat i has the bits above log2(BL) equal to those of the start column. Its low log2(BL) bits equal (start + i) mod BL.
- R4: With `interleave`=1 and length BL, beat i equals the start column with its low log2(BL) bits XORed with i.
- R5: `lenCode` values 0, 1, 2 and 3 select BL = 1, 2, 4 and 8 beats; values 4 to 7 select whole row. A finite burst shows `colValid`=1 for exactly BL consecutive cycles and then drops it. `burstDone` is 1 only during the last beat.
- R6: Whole row (`lenCode` bit 2 set, `interleave`=0) counts columns modulo 512 without end. It never raises `burstDone`, and it runs until a stop or a new start.
- R7: A `stopStb` sampled at an edge without `startStb` makes `colValid` 0 from the next cycle, and `burstDone` is not raised.
- R8: A `startStb` during a running burst replaces it. The next cycle shows the new start column, and strobes on consecutive cycles are each honoured.
- R9: Whole row requested with `interleave`=1 runs as an 8-beat interleaved burst. `modeErr` is then 1 until the next start.
- R10: If `startStb` and `stopStb` are sampled at the same edge, the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Begin (or replace) a burst |
| startCol | input | 9 | Starting column, sampled with startStb |
| lenCode | input | 3 | Burst length code, sampled with startStb |
| interleave | input | 1 | 1 = interleaved ordering, sampled with startStb |
| stopStb | input | 1 | End the running burst |
| colOut | output | 9 | Current column |
| colValid | output | 1 | colOut holds a beat |
| burstDone | output | 1 | Last beat of a finite burst |
| modeErr | output | 1 | Illegal length/ordering pair was requested |

## Verification
The assertions take for granted that `lenCode`, `interleave` and `startCol` matter only in the cycle in which `startStb` is high. They also take for granted that strobes are single-cycle synchronous levels free of X once reset has been released. The stimulus changes every input only on falling clock edges and holds the length and ordering fields steady alongside each strobe. It covers strobe collisions (start with stop, start on consecutive cycles) on purpose, because the block defines a result for them.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } dpCtrl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  output dpCtrl_t          ctl,
  output logic [COL_W-1:0] lenMask,
  output logic             active,
  output logic             lastBeat,
  output logic             modeErr
);
  localparam int SHIFT_W = LEN_W - 1;

  logic [COL_W-1:0] decMask;
  logic             decFull;
  logic             decErr;
  logic [COL_W-1:0] remCnt;
  logic             fullR;

  // length decode, including the illegal whole-row interleave pair
  always_comb begin
    decErr  = 1'b0;
    decFull = 1'b0;
    decMask = COL_W'((COL_W'(1) << lenCode[SHIFT_W-1:0]) - COL_W'(1));
    if (lenCode[LEN_W-1]) begin
      if (interleave) begin
        decErr  = 1'b1;
        decMask = COL_W'(7);
      end else begin
        decFull = 1'b1;
        decMask = '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      remCnt  <= '0;
      fullR   <= 1'b0;
      modeErr <= 1'b0;
      lenMask <= '0;
    end else if (startStb) begin
      active  <= 1'b1;
      remCnt  <= decMask;
      fullR   <= decFull;
      modeErr <= decErr;
      lenMask <= decMask;
    end else if (stopStb) begin
      active <= 1'b0;
    end else if (active) begin
      if (lastBeat) active <= 1'b0;
      else if (!fullR) remCnt <= remCnt - COL_W'(1);
    end
  end

  assign lastBeat = active && !fullR && (remCnt == '0);
  assign ctl.load = startStb;
  assign ctl.step = active && !startStb && !stopStb && !lastBeat;

  // R5
  keep_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !startStb && !stopStb && !lastBeat) |=> active);
  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startStb) |=> !active);
  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> !active);
  // R10
  start_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> active);
  // R9
  err_is_finite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeErr && active) |-> (lenMask == COL_W'(7)));
endmodule

// File: rtl/burst_addr.sv
module burst_addr
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic             interleave,
  input  logic [COL_W-1:0] lenMask,
  output logic [COL_W-1:0] colOut
);
  logic [COL_W-1:0] baseR;
  logic [COL_W-1:0] offsR;
  logic             ilvR;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR <= '0;
      offsR <= '0;
      ilvR  <= 1'b0;
    end else if (ctl.load) begin
      baseR <= startCol;
      offsR <= '0;
      ilvR  <= interleave;
    end else if (ctl.step) begin
      offsR <= offsR + COL_W'(1);
    end
  end

  always_comb begin
    seqCol = (baseR & ~lenMask) | ((baseR + offsR) & lenMask);
    ilvCol = baseR ^ (offsR & lenMask);
    colOut = ilvR ? ilvCol : seqCol;
  end

  // R2
  load_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (colOut == $past(startCol)));
  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ((colOut & ~lenMask) == ($past(colOut) & ~lenMask)));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  input  logic             stopStb,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             burstDone,
  output logic             modeErr
);
  dpCtrl_t          ctl;
  logic [COL_W-1:0] lenMask;

  burst_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .lenCode(lenCode), .interleave(interleave), .ctl(ctl),
    .lenMask(lenMask), .active(colValid), .lastBeat(burstDone),
    .modeErr(modeErr)
  );

  burst_addr #(.COL_W(COL_W)) u_addr (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startCol(startCol),
    .interleave(interleave), .lenMask(lenMask), .colOut(colOut)
  );

  // R5
  done_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> colValid);
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic interleave = 1'b0;
  logic stopStb = 1'b0;
  logic [8:0] colOut;
  logic colValid, burstDone, modeErr;
  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .stopStb(stopStb),
    .colOut(colOut), .colValid(colValid), .burstDone(burstDone),
    .modeErr(modeErr)
  );

  function automatic int beats(input logic [2:0] code, input logic ilv);
    if (code[2]) return ilv ? 8 : 100000;
    return 1 << code[1:0];
  endfunction

  function automatic logic [8:0] expCol(input logic [8:0] b, input logic [2:0] code,
                                        input logic ilv, input int i);
    logic [8:0] m;
    if (code[2] && !ilv) return 9'(int'(b) + i);
    m = 9'(beats(code, ilv) - 1);
    if (ilv) return b ^ (9'(i) & m);
    return (b & ~m) | (9'(int'(b) + i) & m);
  endfunction

  task automatic chk(input string tag, input logic v, input logic [8:0] c, input logic d);
    checks++;
    if (colValid !== v || (v && colOut !== c) || burstDone !== d) begin
      errs++;
      $display("FAIL %s: got valid=%b col=%h done=%b, expected valid=%b col=%h done=%b",
               tag, colValid, colOut, burstDone, v, c, d);
    end
  endtask

  task automatic chkErr(input string tag, input logic e);
    checks++;
    if (modeErr !== e) begin
      errs++;
      $display("FAIL %s: got modeErr=%b, expected %b", tag, modeErr, e);
    end
  endtask

  task automatic issue(input logic [8:0] b, input logic [2:0] code, input logic ilv);
    @(negedge clk);
    startStb = 1'b1; startCol = b; lenCode = code; interleave = ilv;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic runBurst(input string tag, input logic [8:0] b, input logic [2:0] code,
                          input logic ilv);
    int n;
    n = beats(code, ilv);
    issue(b, code, ilv);
    for (int i = 0; i < n; i++) begin
      chk(tag, 1'b1, expCol(b, code, ilv, i), i == n - 1);
      @(negedge clk);
    end
    chk(tag, 1'b0, '0, 1'b0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, '0, 1'b0);
    chkErr("R1 in reset", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, '0, 1'b0);
    chkErr("R1 after reset", 1'b0);
  endtask

  task automatic testLinear();
    runBurst("R3 R5 seq8 R2", 9'h01D, 3'd3, 1'b0);
    runBurst("R3 R5 seq4", 9'h1FE, 3'd2, 1'b0);
    runBurst("R3 R5 seq2", 9'h0A5, 3'd1, 1'b0);
    runBurst("R5 seq1", 9'h123, 3'd0, 1'b0);
  endtask

  task automatic testInterleave();
    runBurst("R4 R5 ilv8", 9'h01D, 3'd3, 1'b1);
    runBurst("R4 R5 ilv4", 9'h0F6, 3'd2, 1'b1);
    runBurst("R4 R5 ilv2", 9'h033, 3'd1, 1'b1);
  endtask

  task automatic testWholeRow();
    issue(9'h1FE, 3'd5, 1'b0);
    for (int i = 0; i < 520; i++) begin
      chk("R6 whole row", 1'b1, expCol(9'h1FE, 3'd5, 1'b0, i), 1'b0);
      @(negedge clk);
    end
    stopStb = 1'b1;
    @(negedge clk);
    stopStb = 1'b0;
    chk("R6 R7 whole row stopped", 1'b0, '0, 1'b0);
  endtask

  task automatic testStop();
    issue(9'h040, 3'd3, 1'b0);
    chk("R7 beat0", 1'b1, 9'h040, 1'b0);
    @(negedge clk);
    chk("R7 beat1", 1'b1, 9'h041, 1'b0);
    stopStb = 1'b1;
    @(negedge clk);
    stopStb = 1'b0;
    chk("R7 stopped", 1'b0, '0, 1'b0);
    @(negedge clk);
    chk("R7 stays stopped", 1'b0, '0, 1'b0);
  endtask

  task automatic testRestart();
    issue(9'h040, 3'd3, 1'b0);
    chk("R8 first beat0", 1'b1, 9'h040, 1'b0);
    @(negedge clk);
    chk("R8 first beat1", 1'b1, 9'h041, 1'b0);
    startStb = 1'b1; startCol = 9'h015; lenCode = 3'd2; interleave = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R8 replaced", 1'b1, expCol(9'h015, 3'd2, 1'b1, i), i == 3);
      @(negedge clk);
    end
    chk("R8 replaced end", 1'b0, '0, 1'b0);
    // strobes on consecutive cycles
    lenCode = 3'd1; interleave = 1'b0;
    for (int k = 0; k < 3; k++) begin
      startStb = 1'b1; startCol = 9'(9'h100 + 9'(k * 6));
      @(negedge clk);
      chk("R8 back to back", 1'b1, 9'(9'h100 + 9'(k * 6)), 1'b0);
    end
    startStb = 1'b0;
    @(negedge clk);
    chk("R8 back to back beat1", 1'b1, 9'h10D, 1'b1);
    @(negedge clk);
    chk("R8 back to back end", 1'b0, '0, 1'b0);
  endtask

  task automatic testIllegal();
    issue(9'h00D, 3'd6, 1'b1);
    chkErr("R9 error raised", 1'b1);
    for (int i = 0; i < 8; i++) begin
      chk("R9 runs as 8", 1'b1, expCol(9'h00D, 3'd3, 1'b1, i), i == 7);
      @(negedge clk);
    end
    chk("R9 ends after 8", 1'b0, '0, 1'b0);
    chkErr("R9 error held", 1'b1);
    runBurst("R9 legal start", 9'h077, 3'd1, 1'b0);
    chkErr("R9 error cleared", 1'b0);
  endtask

  task automatic testCollision();
    issue(9'h033, 3'd2, 1'b0);
    chk("R10 beat0", 1'b1, 9'h033, 1'b0);
    startStb = 1'b1; stopStb = 1'b1; startCol = 9'h080; lenCode = 3'd1; interleave = 1'b0;
    @(negedge clk);
    startStb = 1'b0; stopStb = 1'b0;
    chk("R10 start wins", 1'b1, 9'h080, 1'b0);
    @(negedge clk);
    chk("R10 start wins beat1", 1'b1, 9'h081, 1'b1);
    @(negedge clk);
    chk("R10 end", 1'b0, '0, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    testReset();
    testLinear();
    testInterleave();
    testWholeRow();
    testStop();
    testRestart();
    testIllegal();
    testCollision();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end
endmodule